// File: doc/BRIEF.md
# Four-Function ALU with Operand Select

This block is a small combinational arithmetic and logic unit for a narrow datapath. It takes a primary operand and a second operand, and it computes one of four functions: bitwise AND, bitwise OR, a modular add or subtract, and a signed set-less-than. The second operand comes from one of two inputs. A one-bit select chooses between a register-side port and a separate port that carries an immediate-style value.

The function comes from a three-bit control word. Its low two bits pick the function. Its top bit picks subtract instead of add when the function is add/subtract. Set-less-than always runs through the subtract path, so its outcome does not depend on the top control bit. The result is a single word as wide as the operands, with no flags. A clock input is present for integration only. The result never waits on it.

Top module: `alu4_opsel`

## Requirements
- R1: With ctl[1:0] = 2'b00 the result is the bitwise AND of the first operand and the selected second operand.
- R2: With ctl[1:0] = 2'b01 the result is the bitwise OR of the first operand and the selected second operand.
- R3: With ctl[1:0] = 2'b10 and ctl[2] = 0 the result is the sum of the operands modulo 16, and the carry out is discarded.
- R4: With ctl[1:0] = 2'b10 and ctl[2] = 1 the result is the first operand minus the selected second operand, modulo 16.
- R5: With ctl[1:0] = 2'b11 the result is 4'b0001 when the first operand is less than the second, both read as two's-complement signed values, and 4'b0000 otherwise. This also holds when the subtraction overflows.
- R6: ctl[2] has no effect on the result when ctl[1:0] is 00, 01 or 11.
- R7: With opnd_sel = 0 the second operand is opb, and opimm has no effect. With opnd_sel = 1 the second operand is opimm, and opb has no effect.
- R8: The result depends only on the present data and control inputs. Clock edges leave it unchanged while those inputs are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, accepted for integration, not used by the datapath |
| opa | input | 4 | First operand |
| opb | input | 4 | Register-side candidate for the second operand |
| opimm | input | 4 | Immediate-side candidate for the second operand |
| opnd_sel | input | 1 | Second operand source: 0 selects opb, 1 selects opimm |
| ctl | input | 3 | Control word: [1:0] function, [2] subtract |
| result | output | 4 | Function result |

## Verification
The bench sweeps every combination of the three operand ports, the operand select and the control word. This covers the signed boundaries where set-less-than is hardest. Examples are 7 against 8 and 8 against 7, where the raw difference has the wrong sign. A design that read only the sign of the difference, or compared unsigned, would report the opposite answer there. The sweep also catches a design that let ctl[2] turn set-less-than into an add, or that kept the carry in the sum. For the select, the bench pairs differing values on the two candidate ports, so a swapped or leaking select shows up as a wrong result. A final step holds the inputs across several clock edges to show that the output never latches.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    typedef enum logic [1:0] {
        FN_AND = 2'b00,
        FN_OR  = 2'b01,
        FN_ARI = 2'b10,
        FN_SLT = 2'b11
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    sub;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_ctl(input logic [2:0] raw);
        alu_ctl_t c;
        c.fn  = alu_fn_e'(raw[1:0]);
        c.sub = raw[2];
        return c;
    endfunction

endpackage

// File: rtl/alu4_opnd_mux.sv
module alu4_opnd_mux #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] reg_in,
    input  logic [W-1:0] imm_in,
    input  logic         sel,
    output logic [W-1:0] opnd
);
    logic [W-1:0] opnd_d;

    always_comb begin
        opnd_d = reg_in;
        if (sel) begin
            opnd_d = imm_in;
        end
    end

    assign opnd = opnd_d;

    always @(posedge clk) begin
        // R7
        opnd_src_chk: assert ((opnd == reg_in) || (opnd == imm_in))
            else $error("operand matches neither source");
    end

endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         lt
);
    logic [W-1:0] b_x;
    logic [W-1:0] cin_w;
    logic         ovf;

    always_comb begin
        b_x   = b ^ {W{sub}};
        cin_w = {{(W-1){1'b0}}, sub};
        sum   = a + b_x + cin_w;
        ovf   = (a[W-1] == b_x[W-1]) && (sum[W-1] != a[W-1]);
        lt    = sum[W-1] ^ ovf;
    end

    always @(posedge clk) begin
        // R3
        add_wrap_chk: assert (sub || ((sum - b) == a))
            else $error("sum inconsistent with operands");
        // R4
        sub_wrap_chk: assert (!sub || ((sum + b) == a))
            else $error("difference inconsistent with operands");
    end

endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
    end

    always @(posedge clk) begin
        // R1
        and_sub_chk: assert (((and_o & ~a) == '0) && ((and_o & ~b) == '0))
            else $error("AND output has a bit absent from an operand");
        // R2
        or_cover_chk: assert (((or_o & a) == a) && ((or_o & b) == b))
            else $error("OR output drops an operand bit");
    end

endmodule

// File: rtl/alu4_opsel.sv
module alu4_opsel
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] opimm,
    input  logic         opnd_sel,
    input  logic [2:0]   ctl,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    alu_ctl_t     c_q;
    logic [W-1:0] opnd2;
    logic [W-1:0] sum_w;
    logic         lt_w;
    logic         sub_en;
    logic [W-1:0] and_w;
    logic [W-1:0] or_w;
    logic [W-1:0] res_d;

    assign c_q    = decode_ctl(ctl);
    assign sub_en = c_q.sub || (c_q.fn == FN_SLT);

    alu4_opnd_mux #(.W(W)) i_mux (
        .clk    (clk),
        .reg_in (opb),
        .imm_in (opimm),
        .sel    (opnd_sel),
        .opnd   (opnd2)
    );

    alu4_addsub #(.W(W)) i_addsub (
        .clk (clk),
        .a   (opa),
        .b   (opnd2),
        .sub (sub_en),
        .sum (sum_w),
        .lt  (lt_w)
    );

    alu4_logic #(.W(W)) i_logic (
        .clk   (clk),
        .a     (opa),
        .b     (opnd2),
        .and_o (and_w),
        .or_o  (or_w)
    );

    always_comb begin
        unique case (c_q.fn)
            FN_AND:  res_d = and_w;
            FN_OR:   res_d = or_w;
            FN_ARI:  res_d = sum_w;
            default: res_d = lt_w ? ONE : '0;
        endcase
    end

    assign result = res_d;

    always @(posedge clk) begin
        // R5
        slt_bool_chk: assert ((c_q.fn != FN_SLT) || (result[W-1:1] == '0))
            else $error("set-less-than result has upper bits set");
        // R5
        slt_eq_chk: assert ((c_q.fn != FN_SLT) || (opa != opnd2) || (result == '0))
            else $error("equal operands reported as less-than");
    end

endmodule

// File: tb/test_alu4_opsel.sv
module test_alu4_opsel;
    logic       clk = 1'b0;
    logic [3:0] opa = '0, opb = '0, opimm = '0;
    logic       opnd_sel = 1'b0;
    logic [2:0] ctl = '0;
    logic [3:0] result;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    alu4_opsel i_alu4_opsel (
        .clk(clk), .opa(opa), .opb(opb), .opimm(opimm),
        .opnd_sel(opnd_sel), .ctl(ctl), .result(result)
    );

    function automatic logic [3:0] model(input logic [3:0] a, input logic [3:0] b,
                                         input logic [3:0] im, input logic s,
                                         input logic [2:0] c);
        int sa, sb, y;
        logic [3:0] op2;
        op2 = s ? im : b;
        sa = (a >= 8) ? int'(a) - 16 : int'(a);
        sb = (op2 >= 8) ? int'(op2) - 16 : int'(op2);
        case (c[1:0])
            2'b00: y = int'(a & op2);
            2'b01: y = int'(a | op2);
            2'b10: y = c[2] ? (int'(a) - int'(op2) + 16) % 16 : (int'(a) + int'(op2)) % 16;
            default: y = (sa < sb) ? 1 : 0;
        endcase
        return 4'(y);
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c[1:0])
            2'b00: return c[2] ? "R1/R6" : "R1";
            2'b01: return c[2] ? "R2/R6" : "R2";
            2'b10: return c[2] ? "R4" : "R3";
            default: return c[2] ? "R5/R6" : "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        n_vec++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d imm=%0d sel=%0b ctl=%03b got=%0d exp=%0d",
                     req, opa, opb, opimm, opnd_sel, ctl, result, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        // first vector after power-up: AND of zeros (R1)
        #2 check("R1", 4'd0);
        #3;
        // exhaustive sweep, R1..R7
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        for (int im = 0; im < 16; im++) begin
                            opa = 4'(a); opb = 4'(b); opimm = 4'(im);
                            opnd_sel = 1'(s); ctl = 3'(c);
                            #2;
                            check((b != im) ? {req_of(3'(c)), "/R7"} : req_of(3'(c)),
                                  model(4'(a), 4'(b), 4'(im), 1'(s), 3'(c)));
                            #3;
                        end
                    end
                end
            end
        end
        // signed overflow corners for set-less-than (R5)
        opnd_sel = 1'b0; ctl = 3'b011;
        opa = 4'd7; opb = 4'd8; #2 check("R5", 4'd0); #3;
        opa = 4'd8; opb = 4'd7; #2 check("R5", 4'd1); #3;
        // hold inputs across clock edges (R8)
        opa = 4'd9; opb = 4'd12; opimm = 4'd3; opnd_sel = 1'b1; ctl = 3'b010;
        for (int k = 0; k < 4; k++) begin
            #2 check("R8", 4'd12);
            #18;
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule